// File: doc/BRIEF.md
# Mode-Controlled Timer with Same-Cycle Restart

This block pairs a small control state machine with an up-counter that serves as its timer. The counter advances by one on each cycle in which the count enable is high. When the counter matches a programmable terminal value while enabled, the block raises a terminal-count event.

After a start request the machine sits in a deciding state. In that state it has already latched, from the mode-select input, what the next terminal count must do: restart the timer from zero or let it run on. When the decision is restart, a combinational permission gate lets the terminal-count match clear the counter in the same cycle the match occurs. The counter therefore reads zero right after the event edge, with no extra cycle lost to the state change. In states that grant no permission, a match never touches the counter.

The count and the state come straight from flip-flops. Only the internal clear gate mixes registered state with same-cycle inputs.

Top module: `mode_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the next values are `count`=0, `state`=0 (idle) and `tc_pulse`=0.
- R2: In idle (`state`=0) the counter is held at 0 whatever `cnt_en` does. A high `start` at an edge in idle moves `state` to 1 (choose).
- R3: Outside idle, when no clear applies, `count` rises by exactly one at each edge with `cnt_en` high and keeps its value when `cnt_en` is low.
- R4: A match is a cycle with `state`≠0, `cnt_en`=1 and `count`=`term_val`. `tc_pulse` is high during the cycle after each match and low after every cycle that is not a match.
- R5: A match in choose with the pending decision set to restart makes `count` read 0 after that edge. The clear wins over the increment.
- R6: A match in choose with the pending decision set to run-on does not clear the counter, so `count` becomes `term_val`+1.
- R7: The pending decision is the value of `mode_sel` at the last edge taken in idle or choose (1 = restart, 0 = run-on). A match in choose moves `state` to 3 (restart) when it is 1 and to 2 (run-on) when it is 0.
- R8: A match in state 2 or 3 returns `state` to 1 (choose). With no match, states 1, 2 and 3 hold.
- R9: In state 3 every match clears the counter to 0. In state 2 a match never clears it, and counting wraps from 2^`CNT_W`-1 to 0.
- R10: `start` has no effect outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leaves idle for the choose state |
| cnt_en | input | 1 | Count enable, carry into the incrementer |
| term_val | input | CNT_W | Terminal value compared against the count |
| mode_sel | input | 1 | Pending decision source: 1 restart, 0 run-on |
| count | output | CNT_W | Registered counter value |
| tc_pulse | output | 1 | Registered one-cycle terminal-count pulse |
| state | output | 2 | Registered state: 0 idle, 1 choose, 2 run-on, 3 restart |

## Verification
Several properties are checked on every cycle: the counter step rules (increment, hold, clear-to-zero), the ban on clearing during run-on, the state moves taken on a match in each state, idle holding without `start`, and the reset values. Other behaviour can only be shown by the bench's scenarios. This covers the decision latched from `mode_sel` one cycle before the match, the same-cycle restart at the exact terminal cycle, the wrap through the counter maximum in run-on, and `start` having no effect during a long run-on interval. A behavioural model in the bench follows all of it cycle by cycle, including a long random stretch with small terminal values and a terminal value of zero.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CHOOSE  = 2'd1,
    ST_RUNON   = 2'd2,
    ST_RESTART = 2'd3
  } tmr_state_e;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt_o = cnt_q;

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && inc_i) |=> (cnt_o == $past(cnt_o) + ONE));

  // R3
  hold_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !inc_i) |=> $stable(cnt_o));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && inc_i) |=> (cnt_o == '0));
endmodule

// File: rtl/mt_term_detect.sv
module mt_term_detect #(
  parameter int CNT_W = 8
) (
  input  logic             running_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             hit_o
);
  always_comb begin
    hit_o = running_i && en_i && (cnt_i == term_i);
  end
endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mode_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       mode_sel_i,
  input  logic       hit_i,
  output tmr_state_e state_o,
  output logic       running_o,
  output logic       clr_o,
  output logic       pulse_o
);
  tmr_state_e state_q, state_d;
  logic       pend_q;
  logic       pulse_q;
  logic       permit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CHOOSE;
      ST_CHOOSE:  if (hit_i) state_d = pend_q ? ST_RESTART : ST_RUNON;
      ST_RUNON,
      ST_RESTART: if (hit_i) state_d = ST_CHOOSE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Permission comes from registered state only; the match is same-cycle.
  always_comb begin
    permit = ((state_q == ST_CHOOSE) && pend_q) || (state_q == ST_RESTART);
    clr_o  = (state_q == ST_IDLE) || (hit_i && permit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= hit_i;
      if (state_q == ST_IDLE || state_q == ST_CHOOSE) begin
        pend_q <= mode_sel_i;
      end
    end
  end

  assign state_o   = state_q;
  assign running_o = (state_q != ST_IDLE);
  assign pulse_o   = pulse_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_o == ST_IDLE && !pulse_o));

  // R2
  idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IDLE && !start_i) |=> (state_o == ST_IDLE));

  // R7
  choose_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_CHOOSE && hit_i && pend_q) |=> (state_o == ST_RESTART));

  // R7
  choose_runon_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_CHOOSE && hit_i && !pend_q) |=> (state_o == ST_RUNON));

  // R8
  back_to_choose_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_o == ST_RUNON || state_o == ST_RESTART) && hit_i)
      |=> (state_o == ST_CHOOSE));

  // R4
  pulse_follow_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> pulse_o);
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mode_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] term_val,
  input  logic             mode_sel,
  output logic [CNT_W-1:0] count,
  output logic             tc_pulse,
  output logic [1:0]       state
);
  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  tmr_state_e       fsm_state;
  logic             running;
  logic             hit;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  mt_term_detect #(.CNT_W(CNT_W)) u_detect (
    .running_i (running),
    .en_i      (cnt_en),
    .cnt_i     (cnt),
    .term_i    (term_val),
    .hit_o     (hit)
  );

  mt_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .mode_sel_i (mode_sel),
    .hit_i      (hit),
    .state_o    (fsm_state),
    .running_o  (running),
    .clr_o      (clr),
    .pulse_o    (tc_pulse)
  );

  mt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr),
    .inc_i (cnt_en),
    .cnt_o (cnt)
  );

  assign count = cnt;
  assign state = fsm_state;

  // R9
  runon_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2 && hit) |=> (count == $past(count) + STEP));

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd3 && hit) |=> (count == '0));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0) |=> (count == '0));
endmodule

// File: tb/mode_timer_tb.sv
module mode_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst, start, cnt_en, mode_sel;
  logic [W-1:0] term_val;
  logic [W-1:0] count;
  logic         tc_pulse;
  logic [1:0]   state;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_count, m_state, m_pend, m_tc;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cnt_en(cnt_en),
    .term_val(term_val), .mode_sel(mode_sel),
    .count(count), .tc_pulse(tc_pulse), .state(state)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs with the model (R3 count, R4 pulse, R7 state).
  task automatic compare_all();
    check("R3 count", int'(count), m_count);
    check("R4 tc_pulse", int'(tc_pulse), m_tc);
    check("R7 state", int'(state), m_state);
  endtask

  // One clock: drive at negedge, advance model, compare at next negedge.
  task automatic step(input bit s, input bit e, input bit m, input int t);
    int hit, permit, clr, nc, ns, np;
    start = s; cnt_en = e; mode_sel = m; term_val = W'(t);
    if (rst) begin
      nc = 0; ns = 0; np = 0; hit = 0;
    end else begin
      hit    = (m_state != 0 && e && m_count == t) ? 1 : 0;
      permit = ((m_state == 1 && m_pend == 1) || m_state == 3) ? 1 : 0;
      clr    = (m_state == 0 || (hit && permit)) ? 1 : 0;
      nc     = clr ? 0 : (m_count + (e ? 1 : 0)) % (1 << W);
      np     = (m_state == 0 || m_state == 1) ? int'(m) : m_pend;
      case (m_state)
        0:       ns = s ? 1 : 0;
        1:       ns = hit ? (m_pend ? 3 : 2) : 1;
        default: ns = hit ? 1 : m_state;
      endcase
    end
    @(negedge clk);
    m_count = nc; m_state = ns; m_pend = np; m_tc = hit;
    compare_all();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 0; cnt_en = 0; mode_sel = 0; term_val = '0;
    m_count = 0; m_state = 0; m_pend = 0; m_tc = 0;
    @(negedge clk);
    step(0, 1, 0, 5);
    step(0, 1, 0, 5);
    // R1 reset values
    check("R1 count", int'(count), 0);
    check("R1 state", int'(state), 0);
    check("R1 tc_pulse", int'(tc_pulse), 0);
    rst = 1'b0;

    // R2 idle holds zero with enable high
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0);
    check("R2 idle count", int'(count), 0);
    check("R2 idle state", int'(state), 0);
    step(1, 1, 1, 5);
    check("R2 start->choose", int'(state), 1);

    // choose with restart pending: match at count 5 clears same cycle
    for (int i = 0; i < 5; i++) step(0, 1, 1, 5);
    check("R3 counted to term", int'(count), 5);
    step(0, 1, 1, 5);
    check("R5 same-cycle clear", int'(count), 0);
    check("R7 choose->restart", int'(state), 3);
    check("R4 pulse high", int'(tc_pulse), 1);
    step(0, 1, 0, 5);
    check("R4 pulse single", int'(tc_pulse), 0);

    // R3 hold with enable low
    for (int i = 0; i < 3; i++) step(0, 0, 0, 5);
    check("R3 hold", int'(count), 1);

    // restart state: next match clears and returns to choose
    for (int i = 0; i < 5; i++) step(0, 1, 0, 5);
    check("R9 restart clear", int'(count), 0);
    check("R8 restart->choose", int'(state), 1);

    // choose with run-on pending (mode_sel 0 sampled in choose)
    for (int i = 0; i < 6; i++) step(0, 1, 0, 5);
    check("R6 no clear", int'(count), 6);
    check("R7 choose->runon", int'(state), 2);

    // run-on wraps; start pulses ignored
    for (int i = 0; i < 250; i++) step(1, 1, 1, 5);
    check("R9 wrap", int'(count), 0);
    check("R10 start ignored", int'(state), 2);
    for (int i = 0; i < 6; i++) step(1, 1, 1, 5);
    check("R8 runon->choose", int'(count), 6);
    check("R8 runon state", int'(state), 1);

    // random stretch, model compared every cycle
    begin
      int t;
      t = 3;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 40) == 0) t = $urandom_range(0, 12);
        if (i == 1500) begin
          rst = 1'b1; step(0, 0, 0, t); rst = 1'b0;
          check("R1 mid reset", int'(state), 0);
        end
        step($urandom_range(0, 7) == 0, $urandom_range(0, 3) != 0,
             $urandom_range(0, 1) == 1, t);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule